// File: doc/BRIEF.md
# Two-Signal Edge-Separation Counter

This block measures the interval between an active edge on a start input and a later active edge on a stop input. It counts active edges of a third input, the source, while the interval is open. The source can be a fast reference clock, which makes the result a time, or an event line, which makes the result an event count. Each of the three inputs has its own rising/falling select. The start, stop and source lines are synchronised and edge-detected against the system clock. A software arm pulse readies the block, and finished counts are pushed into a small internal FIFO. The FIFO is read through a valid/ready port.

Two operating modes share one datapath. In single mode the block stores one result and then stays idle until it is armed again. In buffered mode it goes back to waiting for a start after every stop, so one arm yields a stream of results. If a result arrives while the FIFO is full, it is dropped and a sticky overflow flag records the loss.

Top module: `edge_sep_counter`

## Requirements
- R1: After reset the FIFO is empty (`rd_valid_o`=0, `full_o`=0), `overflow_o` is 0, and the block is unarmed.
- R2: Before the first arm pulse, start, stop and source edges produce no result.
- R3: The start line reacts to its rising edge when `start_fall_i`=0 and to its falling edge when it is 1. The stop line is selected the same way by `stop_fall_i`, independently of the start line.
- R4: Between start and stop, the count rises by one on each active source edge: rising when `src_fall_i`=0, falling when it is 1. A source edge in the same clock cycle as the start or the stop edge is not counted.
- R5: Once counting has begun, further active start edges have no effect on the count.
- R6: An active stop edge seen while waiting for a start is ignored.
- R7: With `mode_i`=0 (single), once one result has been stored, every input edge is ignored until the next arm pulse.
- R8: With `mode_i`=1 (buffered), each stop stores one result, clears the count to zero and returns the block to waiting for a start.
- R9: Results leave the FIFO in the order they were stored. `rd_valid_o` shows a result is present, and a result is removed on a cycle with `rd_valid_o` and `rd_ready_i` both high. `full_o` is high when FIFO_DEPTH results are held. Data stays stable while it is not accepted.
- R10: A result that arrives while `full_o` is high is dropped and sets `overflow_o`. The flag stays set until the next arm pulse clears it. FIFO contents are not affected by arm.
- R11: The count wraps modulo 2^CNT_W.
- R12: An arm pulse at any time abandons a measurement in progress without storing it and restarts waiting for a start. Arm takes priority over a stop edge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | One-cycle arm pulse |
| mode_i | input | 1 | 0 single, 1 buffered |
| start_fall_i | input | 1 | Start line active on falling edge when 1 |
| stop_fall_i | input | 1 | Stop line active on falling edge when 1 |
| src_fall_i | input | 1 | Source line active on falling edge when 1 |
| start_i | input | 1 | Asynchronous start line |
| stop_i | input | 1 | Asynchronous stop line |
| src_i | input | 1 | Asynchronous source line |
| rd_ready_i | input | 1 | Reader accepts the head result |
| rd_data_o | output | CNT_W | Head result |
| rd_valid_o | output | 1 | FIFO holds a result |
| full_o | output | 1 | FIFO holds FIFO_DEPTH results |
| overflow_o | output | 1 | Sticky lost-result flag |

## Verification
The bench builds the block with CNT_W=6 and FIFO_DEPTH=4. The narrow counter lets a 70-edge interval run past 63 and exercise the wrap. The shallow FIFO lets a handful of buffered intervals fill it, so dropped results and the sticky flag appear in both the directed and the random phases. Directed cases drive start and source, and stop and source, in the same cycle to check the exclusion rule. They also check that arm recovers from a full FIFO.

// File: rtl/sep_pkg.sv
package sep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_COUNT = 2'd2
    } sep_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic src;
    } sep_evt_s;

    localparam int unsigned NUM_LINES = 3;
    localparam int unsigned LINE_START = 2;
    localparam int unsigned LINE_STOP  = 1;
    localparam int unsigned LINE_SRC   = 0;

    function automatic logic edge_hit(input logic cur, input logic prev, input logic fall);
        return fall ? (prev & ~cur) : (cur & ~prev);
    endfunction

endpackage

// File: rtl/sep_edge_det.sv
module sep_edge_det #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic fall_i,
    output logic evt_o
);
    import sep_pkg::*;

    logic [STAGES:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[STAGES-1:0], pin_i};
        end
    end

    assign evt_o = edge_hit(shift_q[STAGES-1], shift_q[STAGES], fall_i);

endmodule

// File: rtl/sep_ctrl.sv
module sep_ctrl #(
    parameter int unsigned CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    arm_i,
    input  logic                    buffered_i,
    input  sep_pkg::sep_evt_s       evt_i,
    output logic                    push_o,
    output logic [CNT_W-1:0]        push_data_o,
    output sep_pkg::sep_state_e     state_o
);
    import sep_pkg::*;

    sep_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    assign push_o      = (state_q == ST_COUNT) && evt_i.stop && !arm_i;
    assign push_data_o = cnt_q;
    assign state_o     = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (arm_i) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_WAIT: begin
                    if (evt_i.start) begin
                        state_q <= ST_COUNT;
                        cnt_q   <= '0;
                    end
                end
                ST_COUNT: begin
                    if (evt_i.stop) begin
                        state_q <= buffered_i ? ST_WAIT : ST_IDLE;
                        cnt_q   <= '0;
                    end else if (evt_i.src) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/sep_fifo.sv
module sep_fifo #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             rd_ready_i,
    output logic [WIDTH-1:0] rd_data_o,
    output logic             rd_valid_o,
    output logic             full_o
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] used_q;
    logic             do_wr, do_rd;

    assign full_o     = (used_q == FULL_CNT);
    assign rd_valid_o = (used_q != '0);
    assign rd_data_o  = mem_q[rd_ptr_q];
    assign do_wr      = push_i && !full_o;
    assign do_rd      = rd_valid_o && rd_ready_i;

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem_q[wr_ptr_q] <= data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            used_q   <= '0;
        end else begin
            if (do_wr) begin
                wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
            end
            if (do_rd) begin
                rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
            end
            if (do_wr && !do_rd) begin
                used_q <= used_q + 1'b1;
            end else if (do_rd && !do_wr) begin
                used_q <= used_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/edge_sep_counter.sv
module edge_sep_counter #(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned FIFO_DEPTH  = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic             mode_i,
    input  logic             start_fall_i,
    input  logic             stop_fall_i,
    input  logic             src_fall_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             src_i,
    input  logic             rd_ready_i,
    output logic [CNT_W-1:0] rd_data_o,
    output logic             rd_valid_o,
    output logic             full_o,
    output logic             overflow_o
);
    import sep_pkg::*;

    logic [NUM_LINES-1:0] pins, falls, hits;
    sep_evt_s             evt;
    logic                 meas_push;
    logic [CNT_W-1:0]     meas_data;
    sep_state_e           ctrl_state;
    logic                 ovf_q;

    assign pins[LINE_START]  = start_i;
    assign pins[LINE_STOP]   = stop_i;
    assign pins[LINE_SRC]    = src_i;
    assign falls[LINE_START] = start_fall_i;
    assign falls[LINE_STOP]  = stop_fall_i;
    assign falls[LINE_SRC]   = src_fall_i;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        sep_edge_det #(.STAGES(SYNC_STAGES)) u_det (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (pins[g]),
            .fall_i (falls[g]),
            .evt_o  (hits[g])
        );
    end

    assign evt.start = hits[LINE_START];
    assign evt.stop  = hits[LINE_STOP];
    assign evt.src   = hits[LINE_SRC];

    sep_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .arm_i       (arm_i),
        .buffered_i  (mode_i),
        .evt_i       (evt),
        .push_o      (meas_push),
        .push_data_o (meas_data),
        .state_o     (ctrl_state)
    );

    sep_fifo #(.WIDTH(CNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push_i     (meas_push),
        .data_i     (meas_data),
        .rd_ready_i (rd_ready_i),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o),
        .full_o     (full_o)
    );

    always_ff @(posedge clk) begin
        if (rst || arm_i) begin
            ovf_q <= 1'b0;
        end else if (meas_push && full_o) begin
            ovf_q <= 1'b1;
        end
    end

    assign overflow_o = ovf_q;

endmodule

// File: rtl/sep_checker.sv
module sep_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                arm_i,
    input logic                mode_i,
    input logic                rd_ready_i,
    input logic [CNT_W-1:0]    rd_data_o,
    input logic                rd_valid_o,
    input logic                full_o,
    input logic                overflow_o,
    input logic                meas_push,
    input sep_pkg::sep_state_e ctrl_state
);
    import sep_pkg::*;

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rd_valid_o && !overflow_o)); // R1

    AST_NO_RESULT_UNARMED: assert property (@(posedge clk) disable iff (rst)
        (ctrl_state == ST_IDLE) |-> !meas_push); // R2

    AST_SINGLE_GOES_IDLE: assert property (@(posedge clk) disable iff (rst)
        (meas_push && !mode_i) |=> (ctrl_state == ST_IDLE)); // R7

    AST_BUFFERED_REWAITS: assert property (@(posedge clk) disable iff (rst)
        (meas_push && mode_i) |=> (ctrl_state == ST_WAIT)); // R8

    AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        full_o |-> rd_valid_o); // R9

    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (rst)
        (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o))); // R9

    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (meas_push && full_o) |=> overflow_o); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overflow_o && !arm_i) |=> overflow_o); // R10

    AST_ARM_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> !overflow_o); // R10

    AST_ARM_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> (ctrl_state == ST_WAIT)); // R12

endmodule

bind edge_sep_counter sep_checker #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .arm_i      (arm_i),
    .mode_i     (mode_i),
    .rd_ready_i (rd_ready_i),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o),
    .full_o     (full_o),
    .overflow_o (overflow_o),
    .meas_push  (meas_push),
    .ctrl_state (ctrl_state)
);

// File: tb/edge_sep_counter_tb_top.sv
module edge_sep_counter_tb_top;

    localparam int CW    = 6;
    localparam int DEPTH = 4;
    localparam int HOLD  = 4;
    localparam int MODV  = 1 << CW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arm = 1'b0, mode = 1'b0;
    logic pstart = 1'b0, pstop = 1'b0, psrc = 1'b0;
    logic l_start = 1'b0, l_stop = 1'b0, l_src = 1'b0;
    logic rd_ready = 1'b0;
    logic [CW-1:0] rd_data;
    logic rd_valid, full, ovf;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int m_state = 0;
    int m_cnt   = 0;
    bit m_ovf   = 1'b0;
    int exp_q[$];

    always #4 clk = ~clk;

    edge_sep_counter #(.CNT_W(CW), .FIFO_DEPTH(DEPTH), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .arm_i(arm), .mode_i(mode),
        .start_fall_i(pstart), .stop_fall_i(pstop), .src_fall_i(psrc),
        .start_i(l_start), .stop_i(l_stop), .src_i(l_src),
        .rd_ready_i(rd_ready), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
        .full_o(full), .overflow_o(ovf)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic void model_push();
        if (exp_q.size() < DEPTH) exp_q.push_back(m_cnt);
        else m_ovf = 1'b1;
    endfunction

    function automatic void model_edges(input bit s, input bit p, input bit c);
        if (m_state == 1) begin
            if (s) begin m_state = 2; m_cnt = 0; end
        end else if (m_state == 2) begin
            if (p) begin
                model_push();
                m_state = mode ? 1 : 0;
                m_cnt = 0;
            end else if (c) begin
                m_cnt = (m_cnt + 1) % MODV;
            end
        end
    endfunction

    task automatic pulse(input bit s, input bit p, input bit c);
        @(negedge clk);
        if (s) l_start = ~pstart;
        if (p) l_stop  = ~pstop;
        if (c) l_src   = ~psrc;
        wait_n(HOLD);
        l_start = pstart; l_stop = pstop; l_src = psrc;
        wait_n(HOLD);
        model_edges(s, p, c);
    endtask

    task automatic srcs(input int n);
        for (int i = 0; i < n; i++) pulse(0, 0, 1);
    endtask

    task automatic do_arm();
        @(negedge clk);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        m_state = 1; m_cnt = 0; m_ovf = 1'b0;
        wait_n(2);
    endtask

    task automatic configure(input bit md, input bit fs, input bit fp, input bit fc);
        @(negedge clk);
        rst = 1'b1;
        mode = md; pstart = fs; pstop = fp; psrc = fc;
        l_start = fs; l_stop = fp; l_src = fc;
        wait_n(5);
        rst = 1'b0;
        m_state = 0; m_cnt = 0; m_ovf = 1'b0;
        exp_q.delete();
        wait_n(4);
    endtask

    task automatic check_status(input string req);
        @(negedge clk);
        check(full == (exp_q.size() == DEPTH), {req, " full R9"}, int'(full), int'(exp_q.size() == DEPTH));
        check(ovf == m_ovf, {req, " overflow R10"}, int'(ovf), int'(m_ovf));
        check(rd_valid == (exp_q.size() != 0), {req, " valid R9"}, int'(rd_valid), int'(exp_q.size() != 0));
    endtask

    task automatic drain(input string req);
        while (exp_q.size() > 0) begin
            int e;
            @(negedge clk);
            e = exp_q.pop_front();
            check(rd_valid == 1'b1, {req, " valid"}, int'(rd_valid), 1);
            check(int'(rd_data) == e, {req, " data"}, int'(rd_data), e);
            rd_ready = 1'b1;
            @(negedge clk);
            rd_ready = 1'b0;
        end
        @(negedge clk);
        check(rd_valid == 1'b0, {req, " empty after drain"}, int'(rd_valid), 0);
    endtask

    initial begin
        void'($urandom(32'd20240607));
        configure(0, 0, 0, 0);
        @(negedge clk);
        check(rd_valid == 0, "R1 valid after reset", int'(rd_valid), 0);
        check(full == 0, "R1 full after reset", int'(full), 0);
        check(ovf == 0, "R1 overflow after reset", int'(ovf), 0);

        // R2: nothing before arm
        pulse(1, 0, 0); srcs(3); pulse(0, 1, 0);
        check_status("R2 unarmed");
        drain("R2");

        // R5, R7: single mode, repeat start ignored, later edges ignored
        do_arm();
        pulse(1, 0, 0); srcs(5); pulse(1, 0, 0); srcs(2); pulse(0, 1, 0);
        pulse(1, 0, 0); srcs(3); pulse(0, 1, 0);
        check(exp_q.size() == 1 && exp_q[0] == 7, "R5 model", exp_q.size(), 1);
        check_status("R7 single");
        drain("R5 R7 single count");

        // R6, R8: buffered mode, stop before start ignored
        configure(1, 0, 0, 0);
        do_arm();
        pulse(0, 1, 0); pulse(1, 0, 0); srcs(3); pulse(0, 1, 0);
        pulse(1, 0, 0); pulse(0, 1, 0);
        pulse(1, 0, 0); srcs(1); pulse(0, 1, 0);
        check_status("R8 buffered");
        drain("R6 R8 buffered counts");

        // R3, R4: falling polarities everywhere, then mixed
        configure(0, 1, 1, 1);
        do_arm();
        pulse(1, 0, 0); srcs(4); pulse(0, 1, 0);
        drain("R3 R4 falling");
        configure(0, 0, 1, 1);
        do_arm();
        pulse(1, 0, 0); srcs(2); pulse(0, 1, 0);
        drain("R3 R4 mixed");
        configure(1, 1, 0, 0);
        do_arm();
        pulse(1, 0, 0); srcs(3); pulse(0, 1, 0);
        drain("R3 R4 mixed rev");

        // R4: coincident start+src and stop+src not counted
        configure(0, 0, 0, 0);
        do_arm();
        pulse(1, 0, 1); srcs(2); pulse(0, 1, 1);
        check(exp_q.size() == 1 && exp_q[0] == 2, "R4 model", exp_q.size(), 1);
        drain("R4 coincident");

        // R11: wrap
        do_arm();
        pulse(1, 0, 0); srcs(70); pulse(0, 1, 0);
        drain("R11 wrap");

        // R10: overflow and arm clears flag
        configure(1, 0, 0, 0);
        do_arm();
        for (int k = 0; k < 6; k++) begin
            pulse(1, 0, 0); srcs(k); pulse(0, 1, 0);
        end
        check(m_ovf == 1'b1, "R10 model", int'(m_ovf), 1);
        check_status("R10 after overflow");
        do_arm();
        check_status("R10 after arm");
        drain("R10 kept contents");

        // R12: arm mid-measurement
        configure(0, 0, 0, 0);
        do_arm();
        pulse(1, 0, 0); srcs(3); do_arm();
        pulse(1, 0, 0); srcs(1); pulse(0, 1, 0);
        drain("R12 rearm");

        // random phase
        for (int r = 0; r < 5; r++) begin
            configure($urandom_range(1, 0), $urandom_range(1, 0), $urandom_range(1, 0), $urandom_range(1, 0));
            do_arm();
            for (int k = 0; k < 250; k++) begin
                int sel;
                sel = $urandom_range(99, 0);
                if (sel < 50)       pulse(0, 0, 1);
                else if (sel < 62)  pulse(1, 0, 0);
                else if (sel < 74)  pulse(0, 1, 0);
                else if (sel < 80)  pulse(1, 0, 1);
                else if (sel < 85)  pulse(0, 1, 1);
                else if (sel < 88)  do_arm();
                else if (sel < 93)  drain("R4 R8 R9 random");
                else                pulse(1, 1, 0);
                check_status("R4 R10 random");
            end
            drain("R9 random final");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 190000; i++) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule